// File: doc/BRIEF.md
# Key-Protected Frequency Change Trigger Register

This block is a single 32-bit memory-mapped control register that launches a clock frequency change. Software arms the change by writing a longword whose top byte carries a fixed key value and whose least significant bit is 1. If the key matches, the access is a full 32-bit write, the divider configuration is legal and no change is already under way, the register sets its enable bit and sends a one-cycle start pulse to an external frequency-change sequencer.

The enable bit then stays set for the whole change and cannot be rewritten. It clears itself on the clock edge where the sequencer reports completion. Reads return the enable bit in bit 0. Every other bit, the key field included, always reads as zero. Only the power-on or watchdog reset input initialises the register. The sequencer, the PLLs and dividers, and the divider setting register are outside the block. The block sees only a one-bit legality flag from the divider setting register.

Top module: `freq_trig_reg`

## Requirements
- R1: While `rst_n` is low, the enable bit, `seq_start` and `bus_rvalid` are 0. A read after reset returns 0.
- R2: A read is accepted when `bus_valid` is 1 and `bus_write` is 0. `bus_rvalid` is 1 in the cycle after the read is accepted and at no other time. In that cycle `bus_rdata[0]` holds the enable bit and bits 31 to 1 are 0, so the key field also reads as 0.
- R3: A write changes the register only when `bus_wdata[31:24]` equals 0xCF. With any other value in bits 31 to 24 the register is unchanged.
- R4: Only accesses with `bus_be` = 4'b1111 are honoured. A write with any other byte-enable pattern leaves the register unchanged. A read with any other byte-enable pattern returns `bus_rvalid` = 1 with all-zero data.
- R5: Suppose the register is idle and a write is accepted with `bus_wdata[0]` = 1 and `cfg_valid` = 1. Then the enable bit reads 1 from the next cycle on. `seq_start` is 1 for exactly that one cycle.
- R6: A write that would otherwise set the enable bit is ignored when `cfg_valid` is 0 in the write cycle.
- R7: Once set, the enable bit stays 1 until `seq_done` is sampled high. It reads 0 from the following cycle. `seq_done` has no effect while the register is idle.
- R8: While the enable bit is 1, every write is ignored. A write can neither clear the bit nor produce another `seq_start` pulse.
- R9: Write data in bits 23 to 1 has no effect. Those bits always read as 0, and a keyed write with bit 0 = 0 leaves an idle register at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous power-on / watchdog reset |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_be | input | 4 | Byte lane enables |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read |
| cfg_valid | input | 1 | Divider configuration is legal |
| seq_start | output | 1 | One-cycle start request to the sequencer |
| seq_done | input | 1 | Sequencer completion pulse |

## Verification
The assertions assume that the bus holds at most one access per cycle and that `seq_done` is a pulse the sequencer raises only after a start. They also assume that reset is released away from a clock edge. The bench drives every input on the falling clock edge, one access at a time. It raises `seq_done` only while a change is pending, except for the deliberate idle-done case. That case only tests that the register stays at zero, and no assertion depends on `seq_done` being absent while idle.

// File: rtl/ftr_pkg.sv
package ftr_pkg;

    // Classification of the bus access seen in the current cycle
    typedef enum logic [2:0] {
        ACC_NONE      = 3'd0,
        ACC_RD_FULL   = 3'd1,
        ACC_RD_PART   = 3'd2,
        ACC_WR_KEYED  = 3'd3,
        ACC_WR_REJECT = 3'd4
    } access_e;

    // Enable bit state: idle, or a frequency change in progress
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } run_state_e;

endpackage

// File: rtl/ftr_access_decode.sv
module ftr_access_decode
    import ftr_pkg::*;
#(
    parameter int              DATA_W = 32,
    parameter int              KEY_W  = 8,
    parameter logic [KEY_W-1:0] KEY   = 8'hCF,
    parameter int              EN_POS = 0,
    parameter int              BE_W   = DATA_W / 8
) (
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [BE_W-1:0]   bus_be,
    input  logic [DATA_W-1:0] bus_wdata,
    output access_e           acc_kind,
    output logic              req_bit
);

    localparam logic [BE_W-1:0] ALL_LANES = '1;
    localparam int              KEY_LSB   = DATA_W - KEY_W;

    logic key_ok;
    logic full_width;

    always_comb begin
        key_ok     = (bus_wdata[DATA_W-1:KEY_LSB] == KEY);
        full_width = (bus_be == ALL_LANES);
        req_bit    = bus_wdata[EN_POS];

        if (!bus_valid) begin
            acc_kind = ACC_NONE;
        end else if (!bus_write) begin
            acc_kind = full_width ? ACC_RD_FULL : ACC_RD_PART;
        end else if (full_width && key_ok) begin
            acc_kind = ACC_WR_KEYED;
        end else begin
            acc_kind = ACC_WR_REJECT;
        end
    end

endmodule

// File: rtl/ftr_enable_fsm.sv
module ftr_enable_fsm
    import ftr_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  access_e acc_kind,
    input  logic    req_bit,
    input  logic    cfg_valid,
    input  logic    seq_done,
    output logic    en_bit,
    output logic    start_pulse
);

    typedef struct packed {
        run_state_e st;
        logic       start;
    } fsm_t;

    fsm_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.start = 1'b0;
        case (s_q.st)
            ST_IDLE: begin
                // Arm only on a keyed longword write of 1 with a legal divider set
                if (acc_kind == ACC_WR_KEYED && req_bit && cfg_valid) begin
                    s_d.st    = ST_RUN;
                    s_d.start = 1'b1;
                end
            end
            ST_RUN: begin
                // Writes are ignored here; only completion leaves this state
                if (seq_done) begin
                    s_d.st = ST_IDLE;
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: ST_IDLE, start: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign en_bit      = (s_q.st == ST_RUN);
    assign start_pulse = s_q.start;

endmodule

// File: rtl/ftr_read_port.sv
module ftr_read_port
    import ftr_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int EN_POS = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  access_e           acc_kind,
    input  logic              en_bit,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid
);

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] data;
    } rd_t;

    rd_t r_d, r_q;

    always_comb begin
        r_d.valid = 1'b0;
        r_d.data  = '0;
        case (acc_kind)
            ACC_RD_FULL: begin
                r_d.valid        = 1'b1;
                r_d.data[EN_POS] = en_bit;
            end
            ACC_RD_PART: begin
                // Narrow reads complete but carry no register contents
                r_d.valid = 1'b1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign rdata  = r_q.data;
    assign rvalid = r_q.valid;

endmodule

// File: rtl/freq_trig_reg.sv
module freq_trig_reg
    import ftr_pkg::*;
#(
    parameter int               DATA_W = 32,
    parameter int               KEY_W  = 8,
    parameter logic [KEY_W-1:0] KEY    = 8'hCF,
    parameter int               EN_POS = 0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_valid,
    input  logic          bus_write,
    input  logic [3:0]    bus_be,
    input  logic [31:0]   bus_wdata,
    output logic [31:0]   bus_rdata,
    output logic          bus_rvalid,
    input  logic          cfg_valid,
    output logic          seq_start,
    input  logic          seq_done
);

    localparam int BE_W = DATA_W / 8;

    access_e acc_kind;
    logic    req_bit;
    logic    en_q;

    ftr_access_decode #(
        .DATA_W (DATA_W),
        .KEY_W  (KEY_W),
        .KEY    (KEY),
        .EN_POS (EN_POS),
        .BE_W   (BE_W)
    ) u_decode (
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_be    (bus_be),
        .bus_wdata (bus_wdata),
        .acc_kind  (acc_kind),
        .req_bit   (req_bit)
    );

    ftr_enable_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .acc_kind    (acc_kind),
        .req_bit     (req_bit),
        .cfg_valid   (cfg_valid),
        .seq_done    (seq_done),
        .en_bit      (en_q),
        .start_pulse (seq_start)
    );

    ftr_read_port #(
        .DATA_W (DATA_W),
        .EN_POS (EN_POS)
    ) u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .acc_kind (acc_kind),
        .en_bit   (en_q),
        .rdata    (bus_rdata),
        .rvalid   (bus_rvalid)
    );

endmodule

// File: rtl/ftr_chk.sv
module ftr_chk #(
    parameter int               DATA_W = 32,
    parameter int               KEY_W  = 8,
    parameter logic [KEY_W-1:0] KEY    = 8'hCF,
    parameter int               EN_POS = 0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_valid,
    input logic              bus_write,
    input logic [3:0]        bus_be,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              bus_rvalid,
    input logic              cfg_valid,
    input logic              seq_start,
    input logic              seq_done,
    input logic              en_q
);

    logic rd_acc;
    logic keyed_wr;
    assign rd_acc   = bus_valid && !bus_write;
    assign keyed_wr = bus_valid && bus_write && (bus_wdata[DATA_W-1:DATA_W-KEY_W] == KEY);

    assert_rvalid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_acc |=> bus_rvalid);
    assert_rvalid_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_acc |=> !bus_rvalid);
    assert_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rvalid |-> (bus_rdata >> (EN_POS + 1)) == '0);
    assert_key_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_q && !keyed_wr) |=> !en_q);
    assert_lane_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_q && bus_be != 4'hF) |=> !en_q);
    assert_start_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        seq_start |=> !seq_start);
    assert_start_with_en_R5: assert property (@(posedge clk) disable iff (!rst_n)
        seq_start |-> en_q);
    assert_rise_has_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(en_q) |-> seq_start);
    assert_cfg_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_q && !cfg_valid) |=> !en_q);
    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && !seq_done) |=> en_q);
    assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && seq_done) |=> !en_q);
    assert_no_retrigger_R8: assert property (@(posedge clk) disable iff (!rst_n)
        en_q |=> !seq_start);

endmodule

bind freq_trig_reg ftr_chk #(
    .DATA_W (DATA_W),
    .KEY_W  (KEY_W),
    .KEY    (KEY),
    .EN_POS (EN_POS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_valid  (bus_valid),
    .bus_write  (bus_write),
    .bus_be     (bus_be),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .bus_rvalid (bus_rvalid),
    .cfg_valid  (cfg_valid),
    .seq_start  (seq_start),
    .seq_done   (seq_done),
    .en_q       (en_q)
);

// File: tb/freq_trig_reg_bench.sv
`timescale 1ns/1ps
module freq_trig_reg_bench;

    localparam logic [7:0] KEY = 8'hCF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [3:0]  bus_be = 4'h0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;
    logic        cfg_valid = 1'b1;
    logic        seq_start;
    logic        seq_done = 1'b0;

    int n_checks = 0;
    int n_fail   = 0;
    bit exp_en   = 1'b0;
    bit finished = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    freq_trig_reg u_freq_trig_reg (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_valid  (bus_valid),
        .bus_write  (bus_write),
        .bus_be     (bus_be),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .bus_rvalid (bus_rvalid),
        .cfg_valid  (cfg_valid),
        .seq_start  (seq_start),
        .seq_done   (seq_done)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    // Write, then check the start pulse against the model (R5/R8 pulse rules)
    task automatic do_write(input logic [31:0] data, input logic [3:0] be, input string req);
        bit exp_start;
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_be = be; bus_wdata = data;
        exp_start = !exp_en && (be == 4'hF) && (data[31:24] == KEY) && data[0] && cfg_valid;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0; bus_be = 4'h0; bus_wdata = '0;
        if (exp_start) exp_en = 1'b1;
        check(seq_start == exp_start, req, {31'b0, seq_start}, {31'b0, exp_start});
        if (exp_start) begin
            @(negedge clk);
            check(seq_start == 1'b0, "R5 pulse width", {31'b0, seq_start}, 32'h0);
        end
    endtask

    task automatic do_read(input logic [3:0] be, input string req);
        logic [31:0] exp;
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_be = be;
        exp = (be == 4'hF) ? {31'b0, exp_en} : 32'h0;
        @(negedge clk);
        bus_valid = 1'b0; bus_be = 4'h0;
        check(bus_rvalid == 1'b1, "R2 rvalid", {31'b0, bus_rvalid}, 32'h1);
        check(bus_rdata == exp, req, bus_rdata, exp);
        @(negedge clk);
        check(bus_rvalid == 1'b0, "R2 rvalid drop", {31'b0, bus_rvalid}, 32'h0);
    endtask

    task automatic do_done();
        @(negedge clk);
        seq_done = 1'b1;
        @(negedge clk);
        seq_done = 1'b0;
        exp_en = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(bus_rvalid == 1'b0, "R1 rvalid in reset", {31'b0, bus_rvalid}, 32'h0);
        check(seq_start == 1'b0, "R1 start in reset", {31'b0, seq_start}, 32'h0);
        rst_n = 1'b1;
        do_read(4'hF, "R1 read after reset");

        // R3: sweep every key value with a full-width write of 1
        for (int k = 0; k < 256; k++) begin
            do_write({k[7:0], 23'b0, 1'b1}, 4'hF, "R3 key sweep start");
            do_read(4'hF, "R3 key sweep readback");
            if (exp_en) begin
                do_done();
                do_read(4'hF, "R7 clear after done");
            end
        end

        // R4: sweep every byte-enable pattern with the correct key
        for (int b = 0; b < 16; b++) begin
            do_write({KEY, 23'b0, 1'b1}, b[3:0], "R4 lane sweep start");
            do_read(4'hF, "R4 lane sweep readback");
            if (exp_en) begin
                do_read(b[3:0] == 4'hF ? 4'h3 : 4'h1, "R4 narrow read zero");
                do_done();
            end
        end

        // R6: illegal divider configuration blocks the start
        cfg_valid = 1'b0;
        do_write({KEY, 23'b0, 1'b1}, 4'hF, "R6 blocked start");
        do_read(4'hF, "R6 blocked readback");
        cfg_valid = 1'b1;
        do_write({KEY, 23'b0, 1'b1}, 4'hF, "R6 legal start");
        do_read(4'hF, "R6 legal readback");

        // R8: writes during a change neither clear nor retrigger
        cfg_valid = 1'b0;
        do_write({KEY, 23'b0, 1'b0}, 4'hF, "R8 clear attempt");
        cfg_valid = 1'b1;
        do_write({KEY, 23'b0, 1'b0}, 4'hF, "R8 clear attempt");
        do_read(4'hF, "R8 still set");
        do_write({KEY, 23'b0, 1'b1}, 4'hF, "R8 no retrigger");
        do_read(4'hF, "R8 still set");

        // R7: holds without done, clears on done, idle done harmless
        repeat (20) @(negedge clk);
        do_read(4'hF, "R7 hold");
        do_done();
        do_read(4'hF, "R7 cleared");
        do_done();
        do_read(4'hF, "R7 idle done");

        // R9: reserved write bits have no effect
        do_write({KEY, 24'hFFFFFE}, 4'hF, "R9 reserved only");
        do_read(4'hF, "R9 reserved only readback");
        do_write({KEY, 24'hFFFFFF}, 4'hF, "R9 reserved with enable");
        do_read(4'hF, "R9 readback bit0 only");

        // R1: reset during a change clears the register
        @(negedge clk);
        rst_n = 1'b0;
        exp_en = 1'b0;
        @(negedge clk);
        check(bus_rvalid == 1'b0 && seq_start == 1'b0, "R1 mid-run reset",
              {30'b0, bus_rvalid, seq_start}, 32'h0);
        rst_n = 1'b1;
        do_read(4'hF, "R1 cleared by reset");

        finished = 1'b1;
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule